// File: doc/BRIEF.md
# Paged NIC Host Register File

This block is the byte-wide host register interface of a small Ethernet controller. The host sees sixteen byte locations through a 4-bit address. Offset 0 is always the command register. The two top bits of the command register choose which register page the other fifteen offsets reach. The block stores the receive-ring page pointers, the transmit page and byte count, the remote-DMA address and byte count, the receive and data configuration bytes, the six station-address bytes and the eight multicast-filter bytes. It drives all of them out to the neighbouring receive, transmit and DMA engines.

The block also owns the interrupt status and mask registers and drives a level interrupt. Neighbouring engines report events through a set vector. The host acknowledges an event by writing a one to its status bit. Command writes produce one-cycle start, transmit, remote-read and remote-write strobes. Some outcomes the block settles itself: a transmit completes in the register model at once, and a remote transfer of zero bytes completes at once.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command register reads 0x21 (stopped, no DMA, page 0) and interrupt status reads 0x80. Every other register reads 0x00, host_rdata is 0x00 and irq is low.
- R2: The command register is at offset 0 on every page. Bit 0 is stop, bit 1 start, bit 2 transmit, bit 3 remote read, bit 4 remote write, bit 5 no-DMA, and bits 7:6 select the page. A write at a given offset reaches only the register of the selected page.
- R3: A read returns its data in the cycle after host_rd. On page 0, offset 3 gives the boundary, 4 the transmit status, 7 the interrupt status, 8 and 9 the remote-address low and high bytes, 0xA the constant 0x50 and 0xB the constant 0x43. On page 1, offsets 1–6 give the station bytes, 7 the current page and 8–0xF the multicast bytes. On page 2, offsets 1 and 2 give the ring start and stop pages. Every other read returns 0x00.
- R4: On page 0, writes go to these offsets: ring start 1, ring stop 2, boundary 3, transmit page 4, transmit count low 5 and high 6, remote address low 8 and high 9, remote count low 0xA and high 0xB, receive configuration 0xC, data configuration 0xE and mask 0xF. Writing one byte of a 16-bit field leaves the other byte unchanged.
- R5: A write to page 0 offset 7 clears each status bit 6:0 whose written bit is one. Such a write never changes bit 7.
- R6: irq is high exactly when status AND mask AND 0x7F is nonzero. The reset-complete bit 7 never raises irq.
- R7: A command write with bit 0 clear clears status bit 7, and with bit 1 set it also pulses start_pulse for one cycle. A command write with bit 0 set keeps bit 7.
- R8: A command write with bit 0 clear and bit 3 or bit 4 set checks the remote count. If the count is zero, the write sets status bit 6 and issues no DMA strobe. If the count is nonzero, the write pulses dma_rd_pulse (bit 3) or dma_wr_pulse (bit 4) for one cycle.
- R9: A command write with bit 0 clear and bit 2 set loads transmit status with 0x01, sets status bit 1, stores the command with bit 2 cleared and pulses tx_pulse for one cycle.
- R10: Each bit of ev_set sets the status bit of the same index (0 receive ok, 1 transmit ok, 2 receive error, 3 transmit error, 4 ring overwrite, 5 counter overflow, 6 DMA complete). When a set and a host clear of the same bit happen in one cycle, the set wins.
- R11: Page 1 offset 1+k drives phys_addr bits 8k+7:8k, and page 1 offset 8+k drives mcast_filter bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Host register offset |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wdata | input | 8 | Write data |
| ev_set | input | 7 | Event set vector for status bits 6:0 |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |
| start_pulse | output | 1 | Start strobe |
| tx_pulse | output | 1 | Transmit strobe |
| dma_rd_pulse | output | 1 | Remote read strobe |
| dma_wr_pulse | output | 1 | Remote write strobe |
| ring_start | output | 8 | Ring first page |
| ring_stop | output | 8 | Ring end page plus one |
| boundary | output | 8 | Ring boundary page |
| cur_page | output | 8 | Ring current page |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |
| dma_addr | output | 16 | Remote DMA start address |
| dma_count | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration |
| data_cfg | output | 8 | Data configuration |
| phys_addr | output | 48 | Station address bytes |
| mcast_filter | output | 64 | Multicast filter bytes |

## Verification
An event from a neighbouring engine and a host write-one-to-clear to the status register can hit the same status bit in the same cycle. The bench drives ev_set and a status write together in one cycle. It does this once on the same bit and once on different bits. After each case it reads the status back. The set bit must survive and the written bit must clear only where no event arrived.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    typedef logic [7:0] byte_t;

    // command bit positions
    localparam int CMD_STOP  = 0;
    localparam int CMD_START = 1;
    localparam int CMD_XMIT  = 2;
    localparam int CMD_RRD   = 3;
    localparam int CMD_RWR   = 4;

    // interrupt status bit positions
    localparam int ST_TX_OK  = 1;
    localparam int ST_DMA_OK = 6;
    localparam int ST_RESET  = 7;
    localparam int EVT_W     = 7;

    localparam byte_t CMD_AT_RESET = 8'h21;
    localparam byte_t ST_AT_RESET  = 8'h80;
    localparam byte_t ST_IRQ_MASK  = 8'h7F;
    localparam byte_t XMIT_DONE    = 8'h01;

    // effective index = {page, offset}
    localparam int IX_RSTART = 8'h01;
    localparam int IX_RSTOP  = 8'h02;
    localparam int IX_BNDRY  = 8'h03;
    localparam int IX_TXPG   = 8'h04;
    localparam int IX_TXLO   = 8'h05;
    localparam int IX_TXHI   = 8'h06;
    localparam int IX_STAT   = 8'h07;
    localparam int IX_DALO   = 8'h08;
    localparam int IX_DAHI   = 8'h09;
    localparam int IX_DCLO   = 8'h0A;
    localparam int IX_DCHI   = 8'h0B;
    localparam int IX_RXCFG  = 8'h0C;
    localparam int IX_DCFG   = 8'h0E;
    localparam int IX_MASK   = 8'h0F;
    localparam int IX_PHYS   = 8'h11;
    localparam int IX_CURPG  = 8'h17;
    localparam int IX_MCAST  = 8'h18;
    localparam int IX_P2STA  = 8'h21;
    localparam int IX_P2STO  = 8'h22;

endpackage

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
    import nic_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_wr,
    input  byte_t wdata,
    input  logic  dma_cnt_zero,
    output byte_t cmd_q,
    output byte_t xmit_stat_q,
    output logic  start_pulse,
    output logic  tx_pulse,
    output logic  dma_rd_pulse,
    output logic  dma_wr_pulse,
    output byte_t st_set,
    output logic  st_clr_reset
);

    typedef struct packed {
        byte_t cmd;
        byte_t xstat;
        logic  start;
        logic  xmit;
        logic  rrd;
        logic  rwr;
    } cmd_state_t;

    cmd_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.start    = 1'b0;
        s_d.xmit     = 1'b0;
        s_d.rrd      = 1'b0;
        s_d.rwr      = 1'b0;
        st_set       = '0;
        st_clr_reset = 1'b0;
        if (cmd_wr) begin
            s_d.cmd = wdata;
            if (!wdata[CMD_STOP]) begin
                st_clr_reset = 1'b1;
                s_d.start    = wdata[CMD_START];
                if (wdata[CMD_RRD] || wdata[CMD_RWR]) begin
                    if (dma_cnt_zero) begin
                        st_set[ST_DMA_OK] = 1'b1;
                    end else begin
                        s_d.rrd = wdata[CMD_RRD];
                        s_d.rwr = wdata[CMD_RWR];
                    end
                end
                if (wdata[CMD_XMIT]) begin
                    s_d.xstat         = XMIT_DONE;
                    s_d.xmit          = 1'b1;
                    s_d.cmd[CMD_XMIT] = 1'b0;
                    st_set[ST_TX_OK]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cmd   <= CMD_AT_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_q        = s_q.cmd;
    assign xmit_stat_q  = s_q.xstat;
    assign start_pulse  = s_q.start;
    assign tx_pulse     = s_q.xmit;
    assign dma_rd_pulse = s_q.rrd;
    assign dma_wr_pulse = s_q.rwr;

endmodule

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank
    import nic_regs_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int PHYS_BYTES  = 6,
    parameter int MCAST_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [IDX_W-1:0]              idx,
    input  byte_t                         wdata,
    output byte_t                         ring_start,
    output byte_t                         ring_stop,
    output byte_t                         boundary,
    output byte_t                         cur_page,
    output byte_t                         tx_page,
    output logic [15:0]                   tx_count,
    output logic [15:0]                   dma_addr,
    output logic [15:0]                   dma_count,
    output byte_t                         rx_cfg,
    output byte_t                         data_cfg,
    output byte_t                         imr,
    output logic [PHYS_BYTES-1:0][7:0]    phys,
    output logic [MCAST_BYTES-1:0][7:0]   mcast
);

    typedef struct packed {
        byte_t                        rstart;
        byte_t                        rstop;
        byte_t                        bndry;
        byte_t                        curpg;
        byte_t                        txpg;
        logic [15:0]                  txcnt;
        logic [15:0]                  daddr;
        logic [15:0]                  dcnt;
        byte_t                        rxcfg;
        byte_t                        dcfg;
        byte_t                        mask;
        logic [PHYS_BYTES-1:0][7:0]   phys;
        logic [MCAST_BYTES-1:0][7:0]  mcast;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            case (int'(idx))
                IX_RSTART: s_d.rstart      = wdata;
                IX_RSTOP:  s_d.rstop       = wdata;
                IX_BNDRY:  s_d.bndry       = wdata;
                IX_TXPG:   s_d.txpg        = wdata;
                IX_TXLO:   s_d.txcnt[7:0]  = wdata;
                IX_TXHI:   s_d.txcnt[15:8] = wdata;
                IX_DALO:   s_d.daddr[7:0]  = wdata;
                IX_DAHI:   s_d.daddr[15:8] = wdata;
                IX_DCLO:   s_d.dcnt[7:0]   = wdata;
                IX_DCHI:   s_d.dcnt[15:8]  = wdata;
                IX_RXCFG:  s_d.rxcfg       = wdata;
                IX_DCFG:   s_d.dcfg        = wdata;
                IX_MASK:   s_d.mask        = wdata;
                IX_CURPG:  s_d.curpg       = wdata;
                default: ;
            endcase
            for (int k = 0; k < PHYS_BYTES; k++) begin
                if (int'(idx) == IX_PHYS + k) s_d.phys[k] = wdata;
            end
            for (int k = 0; k < MCAST_BYTES; k++) begin
                if (int'(idx) == IX_MCAST + k) s_d.mcast[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ring_start = s_q.rstart;
    assign ring_stop  = s_q.rstop;
    assign boundary   = s_q.bndry;
    assign cur_page   = s_q.curpg;
    assign tx_page    = s_q.txpg;
    assign tx_count   = s_q.txcnt;
    assign dma_addr   = s_q.daddr;
    assign dma_count  = s_q.dcnt;
    assign rx_cfg     = s_q.rxcfg;
    assign data_cfg   = s_q.dcfg;
    assign imr        = s_q.mask;
    assign phys       = s_q.phys;
    assign mcast      = s_q.mcast;

endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
    import nic_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_clr,
    input  logic [EVT_W-1:0] clr_bits,
    input  byte_t            cmd_set,
    input  logic             cmd_clr_reset,
    input  logic [EVT_W-1:0] ev_set,
    input  byte_t            imr,
    output byte_t            isr_q,
    output logic             irq
);

    typedef struct packed {
        byte_t isr;
    } irq_state_t;

    irq_state_t s_d, s_q;
    byte_t clr_mask;
    byte_t set_mask;

    always_comb begin
        clr_mask = '0;
        if (host_clr)      clr_mask[EVT_W-1:0] = clr_bits;
        if (cmd_clr_reset) clr_mask[ST_RESET]  = 1'b1;
        set_mask = cmd_set | {1'b0, ev_set};
        s_d.isr  = (s_q.isr & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.isr <= ST_AT_RESET;
        else        s_q     <= s_d;
    end

    assign isr_q = s_q.isr;
    assign irq   = |(s_q.isr & imr & ST_IRQ_MASK);

endmodule

// File: rtl/nic_read_mux.sv
module nic_read_mux
    import nic_regs_pkg::*;
#(
    parameter int    IDX_W       = 6,
    parameter int    ADDR_W      = 4,
    parameter int    PHYS_BYTES  = 6,
    parameter int    MCAST_BYTES = 8,
    parameter byte_t ID_LO       = 8'h50,
    parameter byte_t ID_HI       = 8'h43
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [IDX_W-1:0]             idx,
    input  byte_t                        cmd,
    input  byte_t                        xstat,
    input  byte_t                        isr,
    input  byte_t                        ring_start,
    input  byte_t                        ring_stop,
    input  byte_t                        boundary,
    input  byte_t                        cur_page,
    input  logic [15:0]                  dma_addr,
    input  logic [PHYS_BYTES-1:0][7:0]   phys,
    input  logic [MCAST_BYTES-1:0][7:0]  mcast,
    output byte_t                        rdata
);

    typedef struct packed {
        byte_t data;
    } rd_state_t;

    rd_state_t s_d, s_q;
    byte_t     sel;

    always_comb begin
        sel = '0;
        if (addr == '0) begin
            sel = cmd;
        end else begin
            case (int'(idx))
                IX_BNDRY: sel = boundary;
                IX_TXPG:  sel = xstat;
                IX_STAT:  sel = isr;
                IX_DALO:  sel = dma_addr[7:0];
                IX_DAHI:  sel = dma_addr[15:8];
                IX_DCLO:  sel = ID_LO;
                IX_DCHI:  sel = ID_HI;
                IX_CURPG: sel = cur_page;
                IX_P2STA: sel = ring_start;
                IX_P2STO: sel = ring_stop;
                default:  sel = '0;
            endcase
            for (int k = 0; k < PHYS_BYTES; k++) begin
                if (int'(idx) == IX_PHYS + k) sel = phys[k];
            end
            for (int k = 0; k < MCAST_BYTES; k++) begin
                if (int'(idx) == IX_MCAST + k) sel = mcast[k];
            end
        end
        s_d = s_q;
        if (rd) s_d.data = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.data;

endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
    import nic_regs_pkg::*;
#(
    parameter int    ADDR_W      = 4,
    parameter int    PAGE_W      = 2,
    parameter int    PHYS_BYTES  = 6,
    parameter int    MCAST_BYTES = 8,
    parameter byte_t ID_LO       = 8'h50,
    parameter byte_t ID_HI       = 8'h43
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [7:0]               host_wdata,
    input  logic [EVT_W-1:0]         ev_set,
    output logic [7:0]               host_rdata,
    output logic                     irq,
    output logic                     start_pulse,
    output logic                     tx_pulse,
    output logic                     dma_rd_pulse,
    output logic                     dma_wr_pulse,
    output logic [7:0]               ring_start,
    output logic [7:0]               ring_stop,
    output logic [7:0]               boundary,
    output logic [7:0]               cur_page,
    output logic [7:0]               tx_page,
    output logic [15:0]              tx_count,
    output logic [15:0]              dma_addr,
    output logic [15:0]              dma_count,
    output logic [7:0]               rx_cfg,
    output logic [7:0]               data_cfg,
    output logic [8*PHYS_BYTES-1:0]  phys_addr,
    output logic [8*MCAST_BYTES-1:0] mcast_filter
);

    localparam int IDX_W = ADDR_W + PAGE_W;

    byte_t                       cmd_q;
    byte_t                       xstat_q;
    byte_t                       isr_q;
    byte_t                       imr_q;
    byte_t                       st_set;
    logic                        st_clr_reset;
    logic [IDX_W-1:0]            eff_idx;
    logic                        cmd_wr;
    logic                        cfg_wr;
    logic                        stat_wr;
    logic [PHYS_BYTES-1:0][7:0]  phys_w;
    logic [MCAST_BYTES-1:0][7:0] mcast_w;

    assign eff_idx = {cmd_q[7 -: PAGE_W], host_addr};
    assign cmd_wr  = host_wr && (host_addr == '0);
    assign cfg_wr  = host_wr && (host_addr != '0);
    assign stat_wr = cfg_wr && (int'(eff_idx) == IX_STAT);

    nic_cmd_unit i_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .wdata        (host_wdata),
        .dma_cnt_zero (dma_count == 16'h0000),
        .cmd_q        (cmd_q),
        .xmit_stat_q  (xstat_q),
        .start_pulse  (start_pulse),
        .tx_pulse     (tx_pulse),
        .dma_rd_pulse (dma_rd_pulse),
        .dma_wr_pulse (dma_wr_pulse),
        .st_set       (st_set),
        .st_clr_reset (st_clr_reset)
    );

    nic_cfg_bank #(
        .IDX_W       (IDX_W),
        .PHYS_BYTES  (PHYS_BYTES),
        .MCAST_BYTES (MCAST_BYTES)
    ) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .idx        (eff_idx),
        .wdata      (host_wdata),
        .ring_start (ring_start),
        .ring_stop  (ring_stop),
        .boundary   (boundary),
        .cur_page   (cur_page),
        .tx_page    (tx_page),
        .tx_count   (tx_count),
        .dma_addr   (dma_addr),
        .dma_count  (dma_count),
        .rx_cfg     (rx_cfg),
        .data_cfg   (data_cfg),
        .imr        (imr_q),
        .phys       (phys_w),
        .mcast      (mcast_w)
    );

    nic_irq_unit i_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_clr      (stat_wr),
        .clr_bits      (host_wdata[EVT_W-1:0]),
        .cmd_set       (st_set),
        .cmd_clr_reset (st_clr_reset),
        .ev_set        (ev_set),
        .imr           (imr_q),
        .isr_q         (isr_q),
        .irq           (irq)
    );

    nic_read_mux #(
        .IDX_W       (IDX_W),
        .ADDR_W      (ADDR_W),
        .PHYS_BYTES  (PHYS_BYTES),
        .MCAST_BYTES (MCAST_BYTES),
        .ID_LO       (ID_LO),
        .ID_HI       (ID_HI)
    ) i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (host_rd),
        .addr       (host_addr),
        .idx        (eff_idx),
        .cmd        (cmd_q),
        .xstat      (xstat_q),
        .isr        (isr_q),
        .ring_start (ring_start),
        .ring_stop  (ring_stop),
        .boundary   (boundary),
        .cur_page   (cur_page),
        .dma_addr   (dma_addr),
        .phys       (phys_w),
        .mcast      (mcast_w),
        .rdata      (host_rdata)
    );

    assign phys_addr    = phys_w;
    assign mcast_filter = mcast_w;

endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk #(
    parameter int ADDR_W = 4,
    parameter int EV_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic [EV_W-1:0]   ev_set,
    input logic              irq,
    input logic              tx_pulse,
    input logic              dma_rd_pulse,
    input logic              dma_wr_pulse,
    input logic [15:0]       dma_count,
    input logic [7:0]        cmd_q,
    input logic [7:0]        isr_q,
    input logic [7:0]        imr_q
);

    assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pulse |-> (isr_q[1] && !cmd_q[2]));

    assert_dma_needs_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_pulse || dma_wr_pulse) |-> (dma_count != 16'h0000));

    assert_run_clears_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == '0 && !host_wdata[0]) |=> !isr_q[7]);

    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(7) && cmd_q[7:6] == 2'b00 && ev_set == '0)
        |=> ((isr_q & $past(host_wdata) & 8'h7F) == 8'h00));

    assert_reset_bit_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_q & 8'h7F) == 8'h00 || imr_q == 8'h00) |-> !irq);

    assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != '0) |=> ((isr_q[EV_W-1:0] & $past(ev_set)) == $past(ev_set)));

endmodule

bind nic_regfile nic_regfile_chk #(.ADDR_W(ADDR_W), .EV_W(nic_regs_pkg::EVT_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .ev_set       (ev_set),
    .irq          (irq),
    .tx_pulse     (tx_pulse),
    .dma_rd_pulse (dma_rd_pulse),
    .dma_wr_pulse (dma_wr_pulse),
    .dma_count    (dma_count),
    .cmd_q        (cmd_q),
    .isr_q        (isr_q),
    .imr_q        (imr_q)
);

// File: tb/test_nic_regfile.sv
module test_nic_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 38;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  host_addr;
    logic        host_wr;
    logic        host_rd;
    logic [7:0]  host_wdata;
    logic [6:0]  ev_set;
    logic [7:0]  host_rdata;
    logic        irq;
    logic        start_pulse, tx_pulse, dma_rd_pulse, dma_wr_pulse;
    logic [7:0]  ring_start, ring_stop, boundary, cur_page, tx_page, rx_cfg, data_cfg;
    logic [15:0] tx_count, dma_addr, dma_count;
    logic [47:0] phys_addr;
    logic [63:0] mcast_filter;

    int checks = 0;
    int fails  = 0;
    logic       p_start, p_tx, p_rrd, p_rwr;
    logic [7:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_regfile i_nic_regfile (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .ev_set(ev_set),
        .host_rdata(host_rdata), .irq(irq), .start_pulse(start_pulse),
        .tx_pulse(tx_pulse), .dma_rd_pulse(dma_rd_pulse), .dma_wr_pulse(dma_wr_pulse),
        .ring_start(ring_start), .ring_stop(ring_stop), .boundary(boundary),
        .cur_page(cur_page), .tx_page(tx_page), .tx_count(tx_count),
        .dma_addr(dma_addr), .dma_count(dma_count), .rx_cfg(rx_cfg),
        .data_cfg(data_cfg), .phys_addr(phys_addr), .mcast_filter(mcast_filter)
    );

    // {is_write, offset, write data, expected read data}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 4'h0, 8'h21, 8'h00}, {1'b0, 4'h7, 8'h00, 8'h80},
        {1'b1, 4'h1, 8'h46, 8'h00}, {1'b1, 4'h2, 8'h80, 8'h00},
        {1'b1, 4'h3, 8'h50, 8'h00}, {1'b1, 4'h8, 8'h34, 8'h00},
        {1'b1, 4'h9, 8'h12, 8'h00}, {1'b0, 4'h8, 8'h00, 8'h34},
        {1'b0, 4'h9, 8'h00, 8'h12}, {1'b0, 4'h3, 8'h00, 8'h50},
        {1'b1, 4'h8, 8'h99, 8'h00}, {1'b0, 4'h9, 8'h00, 8'h12},
        {1'b0, 4'h8, 8'h00, 8'h99}, {1'b0, 4'hA, 8'h00, 8'h50},
        {1'b0, 4'hB, 8'h00, 8'h43}, {1'b0, 4'h5, 8'h00, 8'h00},
        {1'b1, 4'h0, 8'h61, 8'h00}, {1'b1, 4'h1, 8'hAA, 8'h00},
        {1'b1, 4'h6, 8'hFF, 8'h00}, {1'b1, 4'h7, 8'h4C, 8'h00},
        {1'b1, 4'h8, 8'h01, 8'h00}, {1'b1, 4'hF, 8'h80, 8'h00},
        {1'b1, 4'h3, 8'h77, 8'h00}, {1'b0, 4'h1, 8'h00, 8'hAA},
        {1'b0, 4'h6, 8'h00, 8'hFF}, {1'b0, 4'h7, 8'h00, 8'h4C},
        {1'b0, 4'h8, 8'h00, 8'h01}, {1'b0, 4'hF, 8'h00, 8'h80},
        {1'b0, 4'h3, 8'h00, 8'h77}, {1'b0, 4'h0, 8'h00, 8'h61},
        {1'b1, 4'h0, 8'hA1, 8'h00}, {1'b0, 4'h1, 8'h00, 8'h46},
        {1'b0, 4'h2, 8'h00, 8'h80}, {1'b0, 4'h3, 8'h00, 8'h00},
        {1'b1, 4'h0, 8'h21, 8'h00}, {1'b0, 4'h3, 8'h00, 8'h50},
        {1'b0, 4'h4, 8'h00, 8'h00}, {1'b0, 4'h0, 8'h00, 8'h21}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ev(input logic [3:0] a, input logic [7:0] d, input logic [6:0] ev);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1; ev_set = ev;
        @(negedge clk);
        p_start = start_pulse; p_tx = tx_pulse; p_rrd = dma_rd_pulse; p_rwr = dma_wr_pulse;
        host_wr = 1'b0; ev_set = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_ev(a, d, 7'h00);
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        got = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic event_only(input logic [6:0] ev);
        @(negedge clk);
        ev_set = ev;
        @(negedge clk);
        ev_set = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=done");
        fails++;
        checks++;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
        host_wdata = '0; ev_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", host_rdata, 8'h00);
        check("R1 irq", irq, 1'b0);
        rd(4'h0); check("R1 cmd", got, 8'h21);
        rd(4'h7); check("R1 status", got, 8'h80);
        rd(4'h3); check("R1 boundary", got, 8'h00);

        // R2 R3 R4 R7 vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][20]) begin
                wr(VEC[i][19:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][19:16]);
                check($sformatf("R2 R3 vector %0d", i), got, VEC[i][7:0]);
            end
        end

        // R11 configuration outputs
        check("R11 phys byte0", phys_addr[7:0], 8'hAA);
        check("R11 phys byte2", phys_addr[23:16], 8'h77);
        check("R11 phys byte5", phys_addr[47:40], 8'hFF);
        check("R11 mcast byte0", mcast_filter[7:0], 8'h01);
        check("R11 mcast byte7", mcast_filter[63:56], 8'h80);
        check("R4 ring start port", ring_start, 8'h46);

        // R6 reset bit outside mask
        wr(4'hF, 8'hFF);
        check("R6 reset bit no irq", irq, 1'b0);
        // R5 bit 7 not writable-clear
        wr(4'h7, 8'h80);
        rd(4'h7); check("R5 bit7 kept", got, 8'h80);
        // R7 run clears reset bit, start strobe
        wr(4'h0, 8'h22);
        check("R7 start pulse", p_start, 1'b1);
        rd(4'h7); check("R7 reset bit cleared", got, 8'h00);

        // R9 transmit
        wr(4'h4, 8'h40); wr(4'h5, 8'h3C); wr(4'h6, 8'h00);
        check("R4 tx count", tx_count, 16'h003C);
        wr(4'h0, 8'h26);
        check("R9 tx pulse", p_tx, 1'b1);
        check("R9 irq", irq, 1'b1);
        rd(4'h4); check("R9 tx status", got, 8'h01);
        rd(4'h7); check("R9 status", got, 8'h02);
        rd(4'h0); check("R9 cmd bit cleared", got, 8'h22);
        check("R9 pulse one cycle", tx_pulse, 1'b0);

        // R5 clear
        wr(4'h7, 8'h02);
        check("R5 irq after clear", irq, 1'b0);
        rd(4'h7); check("R5 status cleared", got, 8'h00);

        // R8 zero count
        wr(4'h0, 8'h0A);
        check("R8 no read strobe at zero", p_rrd, 1'b0);
        rd(4'h7); check("R8 dma complete", got, 8'h40);
        wr(4'h7, 8'h40);

        // R4 byte halves of remote count
        wr(4'hB, 8'h01);
        check("R4 count high", dma_count, 16'h0100);
        wr(4'hA, 8'h05);
        check("R4 count low", dma_count, 16'h0105);

        // R8 nonzero count strobes
        wr(4'h0, 8'h0A);
        check("R8 read strobe", p_rrd, 1'b1);
        check("R8 no write strobe", p_rwr, 1'b0);
        rd(4'h7); check("R8 no complete", got, 8'h00);
        wr(4'h0, 8'h12);
        check("R8 write strobe", p_rwr, 1'b1);
        check("R8 no read strobe", p_rrd, 1'b0);

        // R10 events and same-cycle clear
        event_only(7'h01);
        rd(4'h7); check("R10 event set", got, 8'h01);
        wr_ev(4'h7, 8'h01, 7'h01);
        rd(4'h7); check("R10 set wins same bit", got, 8'h01);
        wr_ev(4'h7, 8'h01, 7'h04);
        rd(4'h7); check("R10 clear and other set", got, 8'h04);
        wr(4'h7, 8'h7F);
        rd(4'h7); check("R5 clear all", got, 8'h00);

        // R6 mask gating
        wr(4'hF, 8'hDF);
        event_only(7'h20);
        check("R6 masked event", irq, 1'b0);
        rd(4'h7); check("R6 masked status", got, 8'h20);
        event_only(7'h10);
        check("R6 unmasked event", irq, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule